// File: doc/BRIEF.md
# Compressed Parallel Test-Mode Path for a x4 Multiplexed-Address Memory

This block models, in synthesizable form, the test-mode datapath of a memory that stores each external data pin in four internal sub-blocks and picks one of them in normal operation. The strobes (row strobe, column strobe, write enable, all active low) and the multiplexed address are sampled on a system clock. Strobe edges are found by comparing each sample with the one before it. The block sorts every row-strobe cycle into one of three kinds: a row access, a refresh with the column strobe already low, or a row-only refresh. It keeps a single test-mode flag from these cycle kinds.

In normal operation, two column address bits choose which of the four sub-blocks is written or read for every pin. In test mode, a write stores each data bit into the same location of all four sub-blocks at once. A read then returns, per pin, a pass bit that is 1 only when the four stored bits agree. This lets a tester cover the array in a quarter of the accesses. The storage is a small register file whose depth is set by parameters.

The pins carry no back-pressure. A column access is taken on every falling column strobe within an open row. Read data is presented for exactly one cycle with `dout_vld`. Callers must not change the strobes faster than once per clock.

Top module: `dq_compress_tm`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `test_mode` is 0, `dout_vld` is 0 and `dout` is 0.
- R2: A row-strobe fall sampled with the column strobe low, write enable low and address bits [9:0] all 1 sets `test_mode` in the following cycle. Address bits [11:10] do not matter. `test_mode` changes only in the cycle after a row-strobe edge.
- R3: Outside test mode, a row-strobe fall with any of address bits [9:0] at 0 leaves `test_mode` at 0, whatever the other strobes are.
- R4: A row-strobe fall with the column strobe low and write enable high clears `test_mode`. This covers a plain column-before-row refresh and a hidden refresh, where the column strobe stays low from a read across a row-strobe high pulse.
- R5: A row-strobe cycle that ends (row strobe rises) with no column-strobe fall since the row strobe fell clears `test_mode`.
- R6: In test mode, a column-before-row cycle with write enable low keeps `test_mode` at 1, whatever the address is. Ordinary read and write accesses also keep it at 1.
- R7: A normal-mode write (column-strobe fall in an open row, write enable low) stores `din` only in sub-block column[1:0], at word index {row[1:0], column[3:2]}. The other three sub-blocks keep their contents.
- R8: A read (column-strobe fall in an open row, write enable high) drives `dout_vld` high for exactly one cycle, the cycle after the fall is sampled. In normal mode `dout` is the word of sub-block column[1:0] at the indexed location.
- R9: A test-mode write stores `din` at the indexed location of all four sub-blocks.
- R10: A test-mode read gives, for each pin b, `dout[b]` = 1 when bit b of the four sub-block words at the location are all equal, and 0 otherwise.
- R11: Several column accesses within one row-strobe low period (page mode) all use the row address captured at the row-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| din | input | 4 | Write data, one bit per pin |
| dout | output | 4 | Read data or per-pin pass bits |
| dout_vld | output | 1 | One-cycle read data strobe |
| test_mode | output | 1 | Compressed test mode is active |

## Verification
The hardest state to reach from the pins is a location where the four sub-blocks disagree in exactly one pin while the block is in test mode. A test-mode write can only make them agree, and a normal write can only happen outside test mode. The stimulus therefore fills a location in test mode, leaves through a refresh, and overwrites one sub-block with a single flipped bit using a normal write. It then re-enters test mode and checks that only that pin reads 0. Random test-mode writes and reads, and normal readback of all four sub-blocks, run around these directed steps.

// File: rtl/dq_compress_pkg.sv
package dq_compress_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ROW  = 2'd1,
    CYC_REF  = 2'd2
  } cyc_kind_e;

  function automatic logic all_high(input logic [31:0] v, input int unsigned n);
    logic r;
    r = 1'b1;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && !v[i]) r = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/dq_strobe_decode.sv
module dq_strobe_decode
  import dq_compress_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ras_fall,
  output logic              acc_go,
  output logic              ras_only_end,
  output logic [ADDR_W-1:0] row_q
);

  logic      ras_p, cas_p;
  logic      ras_rise, cas_fall;
  logic      cas_seen;
  cyc_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
    end else begin
      ras_p <= ras_n;
      cas_p <= cas_n;
    end
  end

  always_comb begin
    ras_fall     = ras_p & ~ras_n;
    ras_rise     = ~ras_p & ras_n;
    cas_fall     = cas_p & ~cas_n;
    acc_go       = (kind == CYC_ROW) & cas_fall & ~ras_n;
    ras_only_end = (kind == CYC_ROW) & ras_rise & ~cas_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind     <= CYC_IDLE;
      cas_seen <= 1'b0;
      row_q    <= '0;
    end else if (ras_fall) begin
      kind     <= cas_n ? CYC_ROW : CYC_REF;
      cas_seen <= 1'b0;
      row_q    <= addr;
    end else if (ras_rise) begin
      kind     <= CYC_IDLE;
      cas_seen <= 1'b0;
    end else if (acc_go) begin
      cas_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/dq_mode_ctrl.sv
module dq_mode_ctrl
  import dq_compress_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int ENTRY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_fall,
  input  logic              ras_only_end,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              test_q
);

  logic pattern_ok;

  always_comb begin
    pattern_ok = all_high(32'(addr), ENTRY_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= 1'b0;
    end else if (ras_fall && !cas_n) begin
      if (we_n)
        test_q <= 1'b0;
      else if (pattern_ok)
        test_q <= 1'b1;
    end else if (ras_only_end) begin
      test_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dq_sub_array.sv
module dq_sub_array #(
  parameter int DQ_W  = 4,
  parameter int NSUB  = 4,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic [NSUB-1:0]            wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DQ_W-1:0]            wdata,
  output logic [NSUB-1:0][DQ_W-1:0]  rd_words
);

  localparam int DEPTH = 1 << IDX_W;

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    logic [DQ_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[s]) mem[idx] <= wdata;
    end

    always_comb begin
      rd_words[s] = mem[idx];
    end
  end

endmodule

// File: rtl/dq_compress.sv
module dq_compress #(
  parameter int DQ_W  = 4,
  parameter int NSUB  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NSUB-1:0][DQ_W-1:0] rd_words,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      test,
  output logic [DQ_W-1:0]           result
);

  logic [DQ_W-1:0] agree;

  always_comb begin
    for (int b = 0; b < DQ_W; b++) begin
      agree[b] = 1'b1;
      for (int s = 1; s < NSUB; s++) begin
        if (rd_words[s][b] != rd_words[0][b]) agree[b] = 1'b0;
      end
    end
    result = test ? agree : rd_words[sel];
  end

endmodule

// File: rtl/dq_compress_tm.sv
module dq_compress_tm #(
  parameter int ADDR_W    = 12,
  parameter int DQ_W      = 4,
  parameter int SEL_W     = 2,
  parameter int ENTRY_W   = 10,
  parameter int ROW_IDX_W = 2,
  parameter int COL_IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output logic [DQ_W-1:0]   dout,
  output logic              dout_vld,
  output logic              test_mode
);

  localparam int NSUB  = 1 << SEL_W;
  localparam int IDX_W = ROW_IDX_W + COL_IDX_W;

  logic                      ras_fall, acc_go, ras_only_end;
  logic [ADDR_W-1:0]         row_q;
  logic [SEL_W-1:0]          sel;
  logic [IDX_W-1:0]          idx;
  logic [NSUB-1:0]           wr_en;
  logic [NSUB-1:0][DQ_W-1:0] rd_words;
  logic [DQ_W-1:0]           result;

  dq_strobe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .addr(addr),
    .ras_fall(ras_fall), .acc_go(acc_go), .ras_only_end(ras_only_end),
    .row_q(row_q)
  );

  dq_mode_ctrl #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_only_end(ras_only_end),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .test_q(test_mode)
  );

  always_comb begin
    sel = addr[SEL_W-1:0];
    idx = {row_q[ROW_IDX_W-1:0], addr[SEL_W +: COL_IDX_W]};
    for (int s = 0; s < NSUB; s++) begin
      wr_en[s] = acc_go & ~we_n & (test_mode | (sel == SEL_W'(s)));
    end
  end

  dq_sub_array #(.DQ_W(DQ_W), .NSUB(NSUB), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .idx(idx), .wdata(din), .rd_words(rd_words)
  );

  dq_compress #(.DQ_W(DQ_W), .NSUB(NSUB), .SEL_W(SEL_W)) u_cmp (
    .rd_words(rd_words), .sel(sel), .test(test_mode), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= acc_go & we_n;
      if (acc_go && we_n) dout <= result;
    end
  end

endmodule

// File: rtl/dq_compress_tm_chk.sv
module dq_compress_tm_chk #(
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DQ_W-1:0]   dout,
  input logic              dout_vld,
  input logic              test_mode
);

  logic ras_prev;
  logic ras_fell, ras_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ras_prev <= 1'b1;
    else        ras_prev <= ras_n;
  end

  assign ras_fell = ras_prev & ~ras_n;
  assign ras_edge = ras_prev ^ ras_n;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!test_mode && !dout_vld && dout == '0));

  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fell && !cas_n && !we_n && (&addr[9:0])) |=> test_mode);

  p_mode_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_edge |=> $stable(test_mode));

  p_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && ras_fell && !(&addr[9:0])) |=> !test_mode);

  p_refresh_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fell && !cas_n && we_n) |=> !test_mode);

  p_wcbr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && ras_fell && !cas_n && !we_n) |=> test_mode);

  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |=> !dout_vld);

endmodule

bind dq_compress_tm dq_compress_tm_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .dout(dout), .dout_vld(dout_vld), .test_mode(test_mode)
);

// File: tb/dq_compress_tm_test.sv
module dq_compress_tm_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [3:0]  din = '0;
  logic [3:0]  dout;
  logic        dout_vld, test_mode;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] ref_mem [4][16];
  logic [1:0] cur_row;
  bit ref_test;

  always #4 clk = ~clk;

  dq_compress_tm uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld), .test_mode(test_mode)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_read(input logic [3:0] idx, input logic [1:0] sel, input bit tm);
    logic [3:0] r;
    if (!tm) return ref_mem[sel][idx];
    for (int b = 0; b < 4; b++)
      r[b] = (ref_mem[0][idx][b] == ref_mem[1][idx][b]) &&
             (ref_mem[0][idx][b] == ref_mem[2][idx][b]) &&
             (ref_mem[0][idx][b] == ref_mem[3][idx][b]);
    return r;
  endfunction

  task automatic ras_open(input logic [11:0] row);
    addr = row; ras_n = 0; cur_row = row[1:0]; tick();
  endtask

  task automatic ras_close();
    ras_n = 1; tick();
  endtask

  task automatic col_write(input logic [3:0] col, input logic [3:0] d);
    logic [3:0] idx;
    idx = {cur_row, col[3:2]};
    addr = {8'h00, col}; din = d; we_n = 0; cas_n = 0; tick();
    cas_n = 1; we_n = 1; tick();
    if (ref_test) for (int s = 0; s < 4; s++) ref_mem[s][idx] = d;
    else ref_mem[col[1:0]][idx] = d;
  endtask

  task automatic col_read(input logic [3:0] col, input string req, input bit hold);
    addr = {8'h00, col}; we_n = 1; cas_n = 0; tick();
    check({req, " vld"}, 32'(dout_vld), 32'd1);
    check(req, 32'(dout), 32'(exp_read({cur_row, col[3:2]}, col[1:0], ref_test)));
    if (!hold) begin cas_n = 1; tick(); end
  endtask

  task automatic cbr(input logic we, input logic [11:0] a);
    cas_n = 0; we_n = we; tick();
    addr = a; ras_n = 0; tick();
    ras_n = 1; tick();
    cas_n = 1; we_n = 1; tick();
  endtask

  task automatic ras_only(input logic [11:0] row);
    ras_open(row); ras_close();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    ref_test = 0;
    for (int s = 0; s < 4; s++) for (int i = 0; i < 16; i++) ref_mem[s][i] = '0;
    tick(); tick();
    check("R1 reset test_mode", 32'(test_mode), 0);
    check("R1 reset vld", 32'(dout_vld), 0);
    rst_n = 1; tick();
    check("R1 after reset", 32'({test_mode, dout_vld, dout}), 0);

    // fill whole array in normal mode, one page per row (R7, R11)
    for (int r = 0; r < 4; r++) begin
      ras_open({10'($urandom), 2'(r)});
      for (int c = 0; c < 16; c++) col_write(4'(c), 4'($urandom));
      ras_close();
    end
    // page-mode readback of every location (R8, R11)
    for (int r = 0; r < 4; r++) begin
      ras_open({10'h0AA, 2'(r)});
      for (int c = 0; c < 16; c++) col_read(4'(c), "R8 R11 normal read", 0);
      ras_close();
    end
    check("R8 vld single pulse", 32'(dout_vld), 0);

    // random normal traffic: write then verify all four sub-blocks (R7)
    for (int n = 0; n < 30; n++) begin
      logic [3:0] c;
      c = 4'($urandom);
      ras_open({10'($urandom), 2'($urandom)});
      col_write(c, 4'($urandom));
      for (int s = 0; s < 4; s++) col_read({c[3:2], 2'(s)}, "R7 only selected sub written", 0);
      ras_close();
    end

    ras_only(12'hFFF);
    check("R3 ras-only no entry", 32'(test_mode), 0);
    cbr(0, 12'hDFF);
    check("R3 address bit low no entry", 32'(test_mode), 0);
    cbr(1, 12'h3FF);
    check("R3 refresh no entry", 32'(test_mode), 0);
    cbr(0, 12'h7FF);
    check("R2 entry with A11 low A10 high", 32'(test_mode), 1);
    ref_test = 1;

    // test-mode writes and compressed reads (R9, R10)
    for (int n = 0; n < 40; n++) begin
      ras_open({10'($urandom), 2'($urandom)});
      if ($urandom % 2) col_write(4'($urandom), 4'($urandom));
      col_read(4'($urandom), "R10 compressed read", 0);
      ras_close();
    end
    check("R6 accesses keep test mode", 32'(test_mode), 1);
    cbr(0, 12'h000);
    check("R6 wcbr keeps test mode", 32'(test_mode), 1);

    // directed single-bit mismatch per pin
    for (int b = 0; b < 4; b++) begin
      logic [3:0] c, d;
      logic [1:0] rw;
      c = 4'($urandom); d = 4'($urandom); rw = 2'($urandom);
      ras_open({10'h155, rw}); col_write(c, d); ras_close();
      col_check_all: begin
        ras_open({10'h155, rw}); col_read(c, "R9 all agree after test write", 0); ras_close();
        check("R9 pass pattern", 32'(dout), 32'hF);
      end
      cbr(1, 12'h000);
      check("R4 cbr exit", 32'(test_mode), 0);
      ref_test = 0;
      ras_open({10'h155, rw});
      for (int s = 0; s < 4; s++) col_read({c[3:2], 2'(s)}, "R9 every sub-block holds data", 0);
      col_write({c[3:2], 2'(b)}, d ^ (4'b1 << b));
      ras_close();
      cbr(0, 12'hBFF);
      check("R2 re-entry", 32'(test_mode), 1);
      ref_test = 1;
      ras_open({10'h2AA, rw}); col_read(c, "R10 mismatch pin", 0); ras_close();
      check("R10 only that pin zero", 32'(dout), 32'(4'hF & ~(4'b1 << b)));
    end

    ras_only(12'h123);
    check("R5 ras-only exit", 32'(test_mode), 0);
    ref_test = 0;
    cbr(0, 12'h3FF);
    check("R2 entry again", 32'(test_mode), 1);
    ref_test = 1;
    // hidden refresh: read, keep column strobe low, pulse row strobe
    ras_open(12'h001);
    col_read(4'h5, "R10 read before hidden refresh", 1);
    ras_n = 1; tick();
    ras_n = 0; tick();
    ras_n = 1; tick();
    cas_n = 1; tick();
    check("R4 hidden refresh exit", 32'(test_mode), 0);
    ref_test = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule